// File: doc/BRIEF.md
# Multirate Cross-Correlation Time Aligner

This block finds the sample alignment between a high-rate, real-valued reference stream and a feedback stream captured at a rate that is an integer factor `r` below it. Feedback sample `n` is nominally taken at reference index `n*r`. The true capture instant may sit at any of the `r` reference phases, and the feedback may trail the reference by some number of low-rate samples.

The block reads both streams from external buffers through synchronous read ports. It builds `r` decimated copies of the reference, one per phase offset. It correlates each copy against the feedback over a window of `WIN_LEN` low-rate samples, for every lag from zero up to a programmable maximum. The phase whose correlation peak has the largest magnitude wins. A second lag scan then runs on the winning phase and yields the final lag and the signed peak value.

Last, the block streams out the low-rate error sequence between the aligned reference and the feedback. It then raises `done` and holds the result until the next start.

Top module: `mr_time_aligner`

## Requirements
- R1: After reset, `done`, `err_valid`, `phase_idx`, `lag_idx` and `peak` are all zero.
- R2: For phase `p` and lag `k`, the correlation is C(p,k) = sum over n = 0..WIN_LEN-1 of ref[n*r+p] * fb[n+k]. It is a signed product of two's-complement samples, accumulated at full precision in `ACC_W` bits. The reference buffer address is n*r+p and the feedback buffer address is n+k.
- R3: `phase_idx` is the phase whose largest |C(p,k)| over lags 0..max_lag is strictly greatest. On a tie, the lowest phase wins, so all-equal or all-zero correlations give phase 0.
- R4: `lag_idx` is the lag with the strictly largest |C(phase_idx,k)|, where a tie goes to the smallest lag. `peak` is the signed value of C at that lag, and is 0 when every correlation is zero.
- R5: Selection is by magnitude, so a strongly negative correlation wins over a weaker positive one, and `peak` then reports a negative value.
- R6: With ratio 1 and maximum lag 0, the block performs one correlation on phase 0 at lag 0 and reports it.
- R7: `ratio` and `max_lag` are captured when a start is accepted. A start pulse or a change of those inputs while a search runs has no effect on the result or the timing.
- R8: `done` rises at the end of a search and holds, with stable results, until the next start. A start while `done` is high clears `done` in the following cycle and begins a new search.
- R9: Before `done` rises, exactly WIN_LEN error samples appear on `err_data`, each qualified by `err_valid`, in order n = 0,1,... Each value is ref[n*r+phase_idx] - fb[n+lag_idx], given as a DATA_W+1 bit signed value.
- R10: A search takes (r*(max_lag+1) + (max_lag+1) + 1) passes of WIN_LEN+2 cycles each. `done` is high after exactly that many clock edges, counted from the edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a search when idle or done |
| ratio | input | clog2(R_MAX+1) | Rate factor r, 1..R_MAX |
| max_lag | input | clog2(LAG_MAX+1) | Largest lag searched |
| ref_addr | output | clog2(WIN_LEN*R_MAX) | Reference buffer read address |
| ref_data | input | DATA_W | Reference sample, one cycle after its address |
| fb_addr | output | clog2(WIN_LEN+LAG_MAX) | Feedback buffer read address |
| fb_data | input | DATA_W | Feedback sample, one cycle after its address |
| phase_idx | output | clog2(R_MAX) | Selected decimation phase |
| lag_idx | output | clog2(LAG_MAX+1) | Lag at the peak on the selected phase |
| peak | output | ACC_W | Signed correlation at the reported phase and lag |
| done | output | 1 | Search complete, result valid |
| err_valid | output | 1 | Qualifies err_data |
| err_data | output | DATA_W+1 | Aligned reference minus feedback |

## Verification
The checker assumes that an accepted start carries a ratio in 1..R_MAX and a maximum lag no larger than LAG_MAX. Without that, the phase counter never meets its end value and the range properties on the result are meaningless. It also assumes that both buffers return the addressed word one cycle later and are not rewritten during a search. The bench keeps to these limits: it draws ratio and lag from the legal ranges, loads both buffers before each start, and leaves them untouched until `done`. The mid-search start pulse is the one deliberate out-of-window stimulus, and its ratio and lag are also legal.

// File: rtl/mrta_pkg.sv
package mrta_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_EVAL,
      ST_DONE
   } st_t;

   typedef enum logic [1:0] {
      MD_PHASE,
      MD_LAG,
      MD_ERR
   } md_t;

endpackage

// File: rtl/mrta_addr_gen.sv
module mrta_addr_gen #(
   parameter int WIN_LEN = 16384,
   parameter int R_MAX   = 8,
   parameter int N_W     = 14,
   parameter int RA_W    = 17,
   parameter int FA_W    = 15,
   parameter int RATIO_W = 4,
   parameter int PH_W    = 3,
   parameter int LAG_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               step,
   input  logic [RATIO_W-1:0] ratio,
   input  logic [PH_W-1:0]    phase,
   input  logic [LAG_W-1:0]   lag,
   output logic [RA_W-1:0]    ref_addr,
   output logic [FA_W-1:0]    fb_addr,
   output logic               last
);

   logic [N_W-1:0] n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     n_q <= '0;
      else if (clear) n_q <= '0;
      else if (step)  n_q <= n_q + N_W'(1);
   end

   assign last    = (n_q == N_W'(WIN_LEN - 1));
   assign fb_addr = FA_W'(n_q) + FA_W'(lag);

   generate
      if (R_MAX == 1) begin : g_single_rate
         assign ref_addr = RA_W'(n_q);
      end else begin : g_multi_rate
         logic [RA_W-1:0] base_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     base_q <= '0;
            else if (clear) base_q <= '0;
            else if (step)  base_q <= base_q + RA_W'(ratio);
         end
         assign ref_addr = base_q + RA_W'(phase);
      end
   endgenerate

endmodule

// File: rtl/mrta_mac.sv
module mrta_mac #(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 48
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     issue,
   input  logic                     err_mode,
   input  logic signed [DATA_W-1:0] ref_data,
   input  logic signed [DATA_W-1:0] fb_data,
   output logic signed [ACC_W-1:0]  acc,
   output logic                     err_valid,
   output logic signed [DATA_W:0]   err_data
);

   localparam int PROD_W = 2 * DATA_W;

   logic                     val_q;
   logic                     emode_q;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  prod_ext;
   logic signed [DATA_W:0]   diff;

   assign prod     = ref_data * fb_data;
   assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
   assign diff     = {ref_data[DATA_W-1], ref_data} - {fb_data[DATA_W-1], fb_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q     <= 1'b0;
         emode_q   <= 1'b0;
         acc       <= '0;
         err_valid <= 1'b0;
         err_data  <= '0;
      end else begin
         val_q     <= issue;
         emode_q   <= issue & err_mode;
         err_valid <= emode_q;
         if (emode_q) err_data <= diff;
         if (clear)      acc <= '0;
         else if (val_q) acc <= acc + prod_ext;
      end
   end

endmodule

// File: rtl/mr_time_aligner.sv
module mr_time_aligner
   import mrta_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ACC_W   = 48,
   parameter int WIN_LEN = 16384,
   parameter int R_MAX   = 8,
   parameter int LAG_MAX = 63,
   localparam int RATIO_W = $clog2(R_MAX + 1),
   localparam int LAG_W   = $clog2(LAG_MAX + 1) > 0 ? $clog2(LAG_MAX + 1) : 1,
   localparam int PH_W    = R_MAX > 1 ? $clog2(R_MAX) : 1,
   localparam int N_W     = $clog2(WIN_LEN),
   localparam int RA_W    = $clog2(WIN_LEN * R_MAX),
   localparam int FA_W    = $clog2(WIN_LEN + LAG_MAX)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [RATIO_W-1:0]       ratio,
   input  logic [LAG_W-1:0]         max_lag,
   output logic [RA_W-1:0]          ref_addr,
   input  logic signed [DATA_W-1:0] ref_data,
   output logic [FA_W-1:0]          fb_addr,
   input  logic signed [DATA_W-1:0] fb_data,
   output logic [PH_W-1:0]          phase_idx,
   output logic [LAG_W-1:0]         lag_idx,
   output logic signed [ACC_W-1:0]  peak,
   output logic                     done,
   output logic                     err_valid,
   output logic signed [DATA_W:0]   err_data
);

   generate
      if (ACC_W < 2 * DATA_W + $clog2(WIN_LEN)) begin : g_chk_acc
         $error("ACC_W cannot hold a full window of products");
      end
      if (WIN_LEN < 2) begin : g_chk_win
         $error("WIN_LEN must be at least 2");
      end
      if (R_MAX < 1) begin : g_chk_ratio
         $error("R_MAX must be at least 1");
      end
   endgenerate

   st_t st;
   md_t md;

   logic [RATIO_W-1:0]      ratio_l;
   logic [LAG_W-1:0]        lag_l;
   logic [PH_W-1:0]         cur_ph;
   logic [LAG_W-1:0]        cur_lag;
   logic [ACC_W-1:0]        ph_peak;
   logic [ACC_W-1:0]        ph_best_mag;
   logic [ACC_W-1:0]        lag_best_mag;
   logic [PH_W-1:0]         best_ph;
   logic [LAG_W-1:0]        best_lag;
   logic signed [ACC_W-1:0] best_peak;

   logic                    accept;
   logic                    pass_clear;
   logic                    issue;
   logic                    last;
   logic signed [ACC_W-1:0] acc;
   logic [ACC_W-1:0]        mag;
   logic [ACC_W-1:0]        ph_cand;
   logic                    ph_win;
   logic                    ph_last;
   logic                    lag_last;
   logic                    lag_win;
   logic [PH_W-1:0]         sel_ph;

   assign accept     = start && (st == ST_IDLE || st == ST_DONE);
   assign pass_clear = accept || (st == ST_EVAL);
   assign issue      = (st == ST_ISSUE);

   mrta_addr_gen #(
      .WIN_LEN (WIN_LEN),
      .R_MAX   (R_MAX),
      .N_W     (N_W),
      .RA_W    (RA_W),
      .FA_W    (FA_W),
      .RATIO_W (RATIO_W),
      .PH_W    (PH_W),
      .LAG_W   (LAG_W)
   ) i_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (pass_clear),
      .step     (issue),
      .ratio    (ratio_l),
      .phase    (cur_ph),
      .lag      (cur_lag),
      .ref_addr (ref_addr),
      .fb_addr  (fb_addr),
      .last     (last)
   );

   mrta_mac #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W)
   ) i_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (pass_clear),
      .issue     (issue),
      .err_mode  (md == MD_ERR),
      .ref_data  (ref_data),
      .fb_data   (fb_data),
      .acc       (acc),
      .err_valid (err_valid),
      .err_data  (err_data)
   );

   always_comb begin
      mag      = acc[ACC_W-1] ? ACC_W'(-acc) : ACC_W'(acc);
      ph_cand  = (mag > ph_peak) ? mag : ph_peak;
      ph_win   = (ph_cand > ph_best_mag);
      sel_ph   = ph_win ? cur_ph : best_ph;
      ph_last  = ((RATIO_W'(cur_ph) + RATIO_W'(1)) == ratio_l);
      lag_last = (cur_lag == lag_l);
      lag_win  = (mag > lag_best_mag);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         md           <= MD_PHASE;
         ratio_l      <= '0;
         lag_l        <= '0;
         cur_ph       <= '0;
         cur_lag      <= '0;
         ph_peak      <= '0;
         ph_best_mag  <= '0;
         lag_best_mag <= '0;
         best_ph      <= '0;
         best_lag     <= '0;
         best_peak    <= '0;
      end else begin
         case (st)
            ST_IDLE, ST_DONE: begin
               if (accept) begin
                  ratio_l      <= ratio;
                  lag_l        <= max_lag;
                  cur_ph       <= '0;
                  cur_lag      <= '0;
                  md           <= MD_PHASE;
                  ph_peak      <= '0;
                  ph_best_mag  <= '0;
                  lag_best_mag <= '0;
                  best_ph      <= '0;
                  best_lag     <= '0;
                  best_peak    <= '0;
                  st           <= ST_ISSUE;
               end
            end
            ST_ISSUE: if (last) st <= ST_WAIT;
            ST_WAIT:  st <= ST_EVAL;
            ST_EVAL: begin
               st <= ST_ISSUE;
               case (md)
                  MD_PHASE: begin
                     if (!lag_last) begin
                        cur_lag <= cur_lag + LAG_W'(1);
                        ph_peak <= ph_cand;
                     end else begin
                        cur_lag <= '0;
                        ph_peak <= '0;
                        if (ph_win) begin
                           ph_best_mag <= ph_cand;
                           best_ph     <= cur_ph;
                        end
                        if (ph_last) begin
                           md     <= MD_LAG;
                           cur_ph <= sel_ph;
                        end else begin
                           cur_ph <= cur_ph + PH_W'(1);
                        end
                     end
                  end
                  MD_LAG: begin
                     if (lag_win) begin
                        lag_best_mag <= mag;
                        best_lag     <= cur_lag;
                        best_peak    <= acc;
                     end
                     if (lag_last) begin
                        md      <= MD_ERR;
                        cur_lag <= lag_win ? cur_lag : best_lag;
                     end else begin
                        cur_lag <= cur_lag + LAG_W'(1);
                     end
                  end
                  default: st <= ST_DONE;
               endcase
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done      = (st == ST_DONE);
   assign phase_idx = best_ph;
   assign lag_idx   = best_lag;
   assign peak      = best_peak;

endmodule

// File: rtl/mrta_checker.sv
module mrta_checker
   import mrta_pkg::*;
#(
   parameter int ACC_W   = 48,
   parameter int R_MAX   = 8,
   parameter int LAG_MAX = 63,
   parameter int RATIO_W = 4,
   parameter int LAG_W   = 6,
   parameter int PH_W    = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic [RATIO_W-1:0]      ratio,
   input logic [LAG_W-1:0]        max_lag,
   input logic                    done,
   input logic                    err_valid,
   input logic [PH_W-1:0]         phase_idx,
   input logic [LAG_W-1:0]        lag_idx,
   input logic signed [ACC_W-1:0] peak,
   input st_t                     st,
   input logic [RATIO_W-1:0]      ratio_l,
   input logic [LAG_W-1:0]        lag_l
);

   // Input contract: an accepted start carries a legal configuration (R7)
   assert_cfg_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (st == ST_IDLE || st == ST_DONE)) |->
         (ratio != '0 && int'(ratio) <= R_MAX && int'(max_lag) <= LAG_MAX));

   assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ISSUE || st == ST_WAIT || st == ST_EVAL) |=>
         ($stable(ratio_l) && $stable(lag_l)));

   assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> ($stable(phase_idx) && $stable(lag_idx) && $stable(peak)));

   assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> !done);

   assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (RATIO_W'(phase_idx) < ratio_l));

   assert_lag_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lag_idx <= lag_l));

   assert_err_before_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> !done);

endmodule

bind mr_time_aligner mrta_checker #(
   .ACC_W   (ACC_W),
   .R_MAX   (R_MAX),
   .LAG_MAX (LAG_MAX),
   .RATIO_W (RATIO_W),
   .LAG_W   (LAG_W),
   .PH_W    (PH_W)
) i_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .ratio     (ratio),
   .max_lag   (max_lag),
   .done      (done),
   .err_valid (err_valid),
   .phase_idx (phase_idx),
   .lag_idx   (lag_idx),
   .peak      (peak),
   .st        (st),
   .ratio_l   (ratio_l),
   .lag_l     (lag_l)
);

// File: tb/test_mr_time_aligner.sv
module test_mr_time_aligner;

   localparam int CLK_PERIOD = 10;
   localparam int DW    = 16;
   localparam int AW    = 48;
   localparam int N     = 32;
   localparam int RM    = 4;
   localparam int LM    = 7;
   localparam int RT_W  = $clog2(RM + 1);
   localparam int LG_W  = $clog2(LM + 1);
   localparam int PH_W  = $clog2(RM);
   localparam int RA_W  = $clog2(N * RM);
   localparam int FA_W  = $clog2(N + LM);
   localparam int LIMIT = 20000;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [RT_W-1:0]      ratio = '0;
   logic [LG_W-1:0]      max_lag = '0;
   logic [RA_W-1:0]      ref_addr;
   logic [FA_W-1:0]      fb_addr;
   logic signed [DW-1:0] ref_q = '0;
   logic signed [DW-1:0] fb_q = '0;
   logic [PH_W-1:0]      phase_idx;
   logic [LG_W-1:0]      lag_idx;
   logic signed [AW-1:0] peak;
   logic                 done;
   logic                 err_valid;
   logic signed [DW:0]   err_data;

   logic signed [DW-1:0] ref_mem [N*RM];
   logic signed [DW-1:0] fb_mem  [N+LM];

   int total = 0;
   int bad = 0;
   int got_n = 0;
   int got_err [N];
   int exp_ph, exp_lag;
   longint exp_peak;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      ref_q <= ref_mem[ref_addr];
      fb_q  <= fb_mem[fb_addr];
   end

   always @(negedge clk) begin
      if (rst_n && err_valid) begin
         if (got_n < N) got_err[got_n] = int'(err_data);
         got_n = got_n + 1;
      end
   end

   mr_time_aligner #(
      .DATA_W  (DW),
      .ACC_W   (AW),
      .WIN_LEN (N),
      .R_MAX   (RM),
      .LAG_MAX (LM)
   ) i_mr_time_aligner (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ratio     (ratio),
      .max_lag   (max_lag),
      .ref_addr  (ref_addr),
      .ref_data  (ref_q),
      .fb_addr   (fb_addr),
      .fb_data   (fb_q),
      .phase_idx (phase_idx),
      .lag_idx   (lag_idx),
      .peak      (peak),
      .done      (done),
      .err_valid (err_valid),
      .err_data  (err_data)
   );

   task automatic chk(input string req, input longint got, input longint expv);
      total++;
      if (got != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, got, expv);
      end
   endtask

   function automatic logic signed [DW-1:0] rnd16();
      int v;
      v = int'($urandom_range(0, 65534)) - 32767;
      return DW'(v);
   endfunction

   function automatic longint corr(input int r, input int p, input int k);
      longint s = 0;
      for (int n = 0; n < N; n++)
         s += longint'(ref_mem[n*r+p]) * longint'(fb_mem[n+k]);
      return s;
   endfunction

   function automatic longint absl(input longint v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic compute_expected(input int r, input int L);
      longint best = 0;
      exp_ph = 0;
      for (int p = 0; p < r; p++) begin
         longint pk = 0;
         for (int k = 0; k <= L; k++)
            if (absl(corr(r, p, k)) > pk) pk = absl(corr(r, p, k));
         if (pk > best) begin best = pk; exp_ph = p; end
      end
      best = 0; exp_lag = 0; exp_peak = 0;
      for (int k = 0; k <= L; k++) begin
         longint c = corr(r, exp_ph, k);
         if (absl(c) > best) begin best = absl(c); exp_lag = k; exp_peak = c; end
      end
   endtask

   task automatic fill_random();
      for (int i = 0; i < N*RM; i++) ref_mem[i] = rnd16();
      for (int i = 0; i < N+LM; i++) fb_mem[i] = rnd16();
   endtask

   task automatic fill_aligned(input int r, input int p, input int k, input int sgn);
      fill_random();
      for (int n = 0; n < N; n++)
         fb_mem[n+k] = (sgn > 0) ? ref_mem[n*r+p] : DW'(-int'(ref_mem[n*r+p]));
   endtask

   task automatic run_case(input int r, input int L, input bit disturb,
                           input string rq_ph, input string rq_lag);
      int cyc = 0;
      int mism = 0;
      compute_expected(r, L);
      got_n = 0;
      @(negedge clk);
      ratio = RT_W'(r); max_lag = LG_W'(L); start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R8 start clears done", longint'(done), 0);
      while (cyc < LIMIT) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (disturb && cyc == 5) begin
            start = 1'b1; ratio = RT_W'(RM); max_lag = LG_W'(LM);
         end else begin
            start = 1'b0;
         end
         if (done) break;
      end
      if (cyc >= LIMIT) chk("watchdog run", 0, 1);
      chk(disturb ? "R7 timing" : "R10 cycles", cyc, (r*(L+1) + L + 2) * (N + 2));
      chk(rq_ph, longint'(phase_idx), exp_ph);
      chk(rq_lag, longint'(lag_idx), exp_lag);
      chk({rq_lag, " peak"}, longint'(peak), exp_peak);
      chk("R9 error count", got_n, N);
      for (int n = 0; n < N; n++)
         if (got_err[n] != int'(ref_mem[n*r+exp_ph]) - int'(fb_mem[n+exp_lag])) mism++;
      chk("R9 error values", mism, 0);
      repeat (4) @(negedge clk);
      chk("R8 done held", longint'(done), 1);
      chk("R8 phase stable", longint'(phase_idx), exp_ph);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < N*RM; i++) ref_mem[i] = '0;
      for (int i = 0; i < N+LM; i++) fb_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 done", longint'(done), 0);
      chk("R1 err_valid", longint'(err_valid), 0);
      chk("R1 phase", longint'(phase_idx), 0);
      chk("R1 lag", longint'(lag_idx), 0);
      chk("R1 peak", longint'(peak), 0);

      // R2 R3 R4: planted alignment
      fill_aligned(4, 2, 3, 1);
      run_case(4, 7, 1'b0, "R3 phase", "R4 lag");
      fill_aligned(2, 1, 6, 1);
      run_case(2, 6, 1'b0, "R2 phase", "R2 lag");

      // R5: anti-correlated feedback
      fill_aligned(3, 1, 5, -1);
      run_case(3, 6, 1'b0, "R5 phase", "R5 lag");

      // R6: ratio 1, lag 0
      fill_aligned(1, 0, 0, 1);
      run_case(1, 0, 1'b0, "R6 phase", "R6 lag");

      // R3 R4 ties: identical phases, constant feedback
      for (int n = 0; n < N; n++) begin
         logic signed [DW-1:0] v;
         v = DW'($urandom_range(1, 100));
         for (int p = 0; p < 4; p++) ref_mem[n*4+p] = v;
      end
      for (int i = 0; i < N+LM; i++) fb_mem[i] = 16'sd100;
      run_case(4, 3, 1'b0, "R3 tie phase", "R4 tie lag");

      // R4 all zero
      for (int i = 0; i < N*RM; i++) ref_mem[i] = '0;
      for (int i = 0; i < N+LM; i++) fb_mem[i] = '0;
      run_case(2, 2, 1'b0, "R3 zero phase", "R4 zero lag");

      // R7: start and config changes mid-search ignored
      fill_aligned(2, 1, 2, 1);
      run_case(2, 4, 1'b1, "R7 phase", "R7 lag");

      // R10 corner: largest ratio and lag
      fill_aligned(RM, RM-1, LM, 1);
      run_case(RM, LM, 1'b0, "R3 max phase", "R4 max lag");

      // constrained random trials
      for (int t = 0; t < 6; t++) begin
         int r, L;
         r = int'($urandom_range(1, RM));
         L = int'($urandom_range(0, LM));
         if ($urandom_range(0, 1) == 1)
            fill_aligned(r, int'($urandom_range(0, r-1)), int'($urandom_range(0, L)), 1);
         else
            fill_random();
         run_case(r, L, 1'b0, "R3 random phase", "R4 random lag");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule